// File: doc/BRIEF.md
# Address Aperture Decoder with Load Hole

This block sorts every 32-bit processor address into exactly one of four targets: a small absorbing window at the very bottom of the address space (the load hole), a relocatable DRAM window, a fixed-size register (MMIO) window, or the external PCI bus, which takes everything else. The decode is purely combinational. It depends on the address, a load/store flag and a small set of configuration registers held inside the block. The output is a one-hot target select. A separate flag tells the data path to return zero for a load, because that load is absorbed and causes no external access.

The bottom 256 bytes stop speculative loads from becoming slow bus reads. Stores are never absorbed; they go wherever the window registers send them. When the DRAM window reaches down into the hole, the hole is switched off entirely. The DRAM window is given by an inclusive base and limit, and its size is capped at 64 MB from its base. The MMIO window is always 2 MB long and starts on a 2 MB boundary.

Configuration is written through plain control pins: a write strobe, a register code and a data word. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge where the strobe is sampled, and decodes made after that edge use the new value.

Top module: `aperture_decoder`

## Requirements
- R1: After reset the hole is enabled, the MMIO base is 0xEFE00000, and the DRAM window is empty (base 0x01000000, limit 0x00FFFFFF), so no address decodes to DRAM.
- R2: `tgt_sel` is always exactly one-hot, with bit 0 = PCI, bit 1 = MMIO, bit 2 = DRAM and bit 3 = hole. `zero_fill` equals bit 3.
- R3: A load (`acc_is_load`=1) to an address from 0x00 to 0xFF, while the hole is active, selects the hole and raises `zero_fill`.
- R4: A store to an address from 0x00 to 0xFF never selects the hole. It goes to DRAM, MMIO or PCI according to the windows.
- R5: When the DRAM window is non-empty and its base is at or below 0xFF, the hole is inactive. Loads at 0x00 to 0xFF then decode as DRAM if inside the DRAM window, and otherwise as MMIO or PCI.
- R6: Bit 0 of the control register (code 3) enables the hole. While it is 0, loads at 0x00 to 0xFF decode as if the hole did not exist.
- R7: An address decodes as DRAM when base <= addr <= limit, compared unsigned with both bounds inclusive. DRAM takes priority over MMIO and PCI.
- R8: The DRAM window never extends beyond base + 0x3FFFFFF (64 MB), even if the limit is higher.
- R9: The MMIO window covers 2 MB starting at the MMIO base. Writes to the MMIO base ignore data bits 20:0.
- R10: An address in none of the hole, DRAM or MMIO windows decodes as PCI.
- R11: With `cfg_we`=1 at a rising clock edge, `cfg_wdata` is written to the register named by `cfg_sel` (0 DRAM base, 1 DRAM limit, 2 MMIO base, 3 control). The new value governs decodes after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register code for the write |
| cfg_wdata | input | 32 | Write data |
| acc_addr | input | 32 | Address being decoded |
| acc_is_load | input | 1 | 1 for a load, 0 for a store |
| tgt_sel | output | 4 | One-hot target: PCI, MMIO, DRAM, hole |
| zero_fill | output | 1 | Load is absorbed; return zero |

## Verification
Loads and stores are applied to the same low addresses. This separates absorption from routing, and shows that stores follow the windows even when the MMIO base is moved to zero. Addresses just inside and just outside each window edge test the inclusive DRAM bounds, the 64 MB cap, the 2 MB MMIO span and the unsigned compare at the top half of the address space. DRAM windows that start below, and inside, the hole range distinguish "hole yields to DRAM" from plain priority. Toggling the enable bit shows that the hole switch alone changes the low-address load result.

// File: rtl/apdec_pkg.sv
package apdec_pkg;
  // one-hot target bit positions on tgt_sel
  localparam int TGT_PCI  = 0;
  localparam int TGT_MMIO = 1;
  localparam int TGT_DRAM = 2;
  localparam int TGT_HOLE = 3;
  localparam int TGT_N    = 4;

  typedef enum logic [1:0] {
    CFG_DRAM_BASE  = 2'd0,
    CFG_DRAM_LIMIT = 2'd1,
    CFG_MMIO_BASE  = 2'd2,
    CFG_CTRL       = 2'd3
  } cfg_code_e;
endpackage

// File: rtl/apdec_cfg_regs.sv
module apdec_cfg_regs
  import apdec_pkg::*;
#(
  parameter int          ADDR_W          = 32,
  parameter int          MMIO_BITS       = 21,
  parameter logic [31:0] RST_DRAM_BASE   = 32'h0100_0000,
  parameter logic [31:0] RST_DRAM_LIMIT  = 32'h00FF_FFFF,
  parameter logic [31:0] RST_MMIO_BASE   = 32'hEFE0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] dram_base,
  output logic [ADDR_W-1:0] dram_limit,
  output logic [ADDR_W-1:0] mmio_base,
  output logic              hole_en
);
  localparam int MHI = ADDR_W - MMIO_BITS;

  logic [MHI-1:0] mmio_hi_q;
  cfg_code_e      code;

  assign code = cfg_code_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_base  <= RST_DRAM_BASE[ADDR_W-1:0];
      dram_limit <= RST_DRAM_LIMIT[ADDR_W-1:0];
      mmio_hi_q  <= RST_MMIO_BASE[ADDR_W-1:MMIO_BITS];
      hole_en    <= 1'b1;
    end else if (cfg_we) begin
      unique case (code)
        CFG_DRAM_BASE:  dram_base  <= cfg_wdata;
        CFG_DRAM_LIMIT: dram_limit <= cfg_wdata;
        CFG_MMIO_BASE:  mmio_hi_q  <= cfg_wdata[ADDR_W-1:MMIO_BITS];
        CFG_CTRL:       hole_en    <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  assign mmio_base = {mmio_hi_q, {MMIO_BITS{1'b0}}};

  // R9 / R11: MMIO base write keeps only the aligned part of the data
  assert_mmio_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2) |=>
      (mmio_base[ADDR_W-1:MMIO_BITS] == $past(cfg_wdata[ADDR_W-1:MMIO_BITS])
       && mmio_base[MMIO_BITS-1:0] == '0));

  // R11: control write lands in the enable bit
  assert_ctrl_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> (hole_en == $past(cfg_wdata[0])));

  // R11: registers hold when no write strobe
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && $past(rst_n)) |=> ($stable(dram_base) && $stable(dram_limit)
                                   && $stable(mmio_base) && $stable(hole_en)));
endmodule

// File: rtl/apdec_window.sv
module apdec_window #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_BITS = 21,
  parameter bit BOUNDED   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              hit,
  output logic              valid
);
  localparam int HI = ADDR_W - SPAN_BITS;

  generate
    if (BOUNDED) begin : g_bounded
      logic [ADDR_W-1:0] offs;
      logic              above, below, in_cap;
      assign offs   = addr - base;
      assign above  = addr >= base;
      assign below  = addr <= limit;
      assign in_cap = (offs[ADDR_W-1:SPAN_BITS] == '0);
      assign valid  = base <= limit;
      assign hit    = above && below && in_cap;

      // R7: a hit is inside the inclusive bounds
      assert_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (addr >= base && addr <= limit));
      // R8: a hit never lies past the size cap
      assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ({1'b0, addr} < ({1'b0, base} + (33'd1 << SPAN_BITS))));
    end else begin : g_fixed
      logic unused_fixed;
      assign unused_fixed = ^{limit, base[SPAN_BITS-1:0], clk, rst_n};
      assign valid = 1'b1;
      assign hit   = (addr[ADDR_W-1:SPAN_BITS] == base[ADDR_W-1:SPAN_BITS]);
    end
  endgenerate

  logic unused_hi;
  assign unused_hi = (HI == 0);
endmodule

// File: rtl/apdec_select.sv
module apdec_select
  import apdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_load,
  input  logic             hole_active,
  input  logic             hole_hit,
  input  logic             dram_hit,
  input  logic             mmio_hit,
  output logic [TGT_N-1:0] tgt_sel,
  output logic             zero_fill
);
  always_comb begin
    tgt_sel = '0;
    if (is_load && hole_active && hole_hit) tgt_sel[TGT_HOLE] = 1'b1;
    else if (dram_hit)                      tgt_sel[TGT_DRAM] = 1'b1;
    else if (mmio_hit)                      tgt_sel[TGT_MMIO] = 1'b1;
    else                                    tgt_sel[TGT_PCI]  = 1'b1;
  end

  assign zero_fill = tgt_sel[TGT_HOLE];

  // R2: exactly one target
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tgt_sel) == 1);
  // R3: absorption only for loads
  assert_fill_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fill |-> (is_load && hole_hit));
  // R4: stores never land in the hole
  assert_store_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_load |-> !tgt_sel[TGT_HOLE]);
  // R5 / R6: inactive hole never absorbs
  assert_hole_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hole_active |-> !zero_fill);
  // R10: PCI only when no window matched
  assert_pci_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[TGT_PCI] |-> (!dram_hit && !mmio_hit));
endmodule

// File: rtl/aperture_decoder.sv
module aperture_decoder
  import apdec_pkg::*;
#(
  parameter int          ADDR_W         = 32,
  parameter int          HOLE_BITS      = 8,
  parameter int          MMIO_BITS      = 21,
  parameter int          DRAM_MAX_BITS  = 26,
  parameter logic [31:0] RST_DRAM_BASE  = 32'h0100_0000,
  parameter logic [31:0] RST_DRAM_LIMIT = 32'h00FF_FFFF,
  parameter logic [31:0] RST_MMIO_BASE  = 32'hEFE0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_load,
  output logic [3:0]        tgt_sel,
  output logic              zero_fill
);
  localparam logic [ADDR_W-1:0] HOLE_TOP = ADDR_W'((1 << HOLE_BITS) - 1);

  logic [ADDR_W-1:0] dram_base, dram_limit, mmio_base;
  logic              hole_en, hole_hit, dram_hit, mmio_hit;
  logic              dram_valid, hole_valid_unused, mmio_valid_unused;
  logic              hole_active;
  logic              unused_v;

  apdec_cfg_regs #(
    .ADDR_W(ADDR_W), .MMIO_BITS(MMIO_BITS),
    .RST_DRAM_BASE(RST_DRAM_BASE), .RST_DRAM_LIMIT(RST_DRAM_LIMIT),
    .RST_MMIO_BASE(RST_MMIO_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dram_base(dram_base), .dram_limit(dram_limit),
    .mmio_base(mmio_base), .hole_en(hole_en)
  );

  apdec_window #(.ADDR_W(ADDR_W), .SPAN_BITS(HOLE_BITS), .BOUNDED(1'b0)) u_hole (
    .clk(clk), .rst_n(rst_n), .addr(acc_addr), .base('0), .limit('0),
    .hit(hole_hit), .valid(hole_valid_unused)
  );

  apdec_window #(.ADDR_W(ADDR_W), .SPAN_BITS(DRAM_MAX_BITS), .BOUNDED(1'b1)) u_dram (
    .clk(clk), .rst_n(rst_n), .addr(acc_addr), .base(dram_base), .limit(dram_limit),
    .hit(dram_hit), .valid(dram_valid)
  );

  apdec_window #(.ADDR_W(ADDR_W), .SPAN_BITS(MMIO_BITS), .BOUNDED(1'b0)) u_mmio (
    .clk(clk), .rst_n(rst_n), .addr(acc_addr), .base(mmio_base), .limit('0),
    .hit(mmio_hit), .valid(mmio_valid_unused)
  );

  assign unused_v = hole_valid_unused ^ mmio_valid_unused;

  // hole yields entirely when a live DRAM window reaches into it
  assign hole_active = hole_en && !(dram_valid && dram_base <= HOLE_TOP);

  apdec_select u_sel (
    .clk(clk), .rst_n(rst_n), .is_load(acc_is_load), .hole_active(hole_active),
    .hole_hit(hole_hit), .dram_hit(dram_hit), .mmio_hit(mmio_hit),
    .tgt_sel(tgt_sel), .zero_fill(zero_fill)
  );

  // R5: a DRAM window covering low memory disables absorption
  assert_hole_yields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_valid && dram_base <= HOLE_TOP) |-> !zero_fill);
  // R6: cleared enable disables absorption
  assert_hole_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hole_en |-> !zero_fill);
endmodule

// File: tb/aperture_decoder_tb.sv
module aperture_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_is_load = 1'b0;
  logic [3:0]  tgt_sel;
  logic        zero_fill;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [3:0] PCI  = 4'b0001;
  localparam logic [3:0] MMIO = 4'b0010;
  localparam logic [3:0] DRAM = 4'b0100;
  localparam logic [3:0] HOLE = 4'b1000;

  always #10 clk = ~clk;

  aperture_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_is_load(acc_is_load),
    .tgt_sel(tgt_sel), .zero_fill(zero_fill)
  );

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic ld,
                       input logic [3:0] exp_t);
    logic exp_z;
    exp_z = (exp_t == HOLE);
    acc_addr = a; acc_is_load = ld;
    #2;
    n_chk++;
    if (tgt_sel !== exp_t || zero_fill !== exp_z) begin
      n_bad++;
      $display("FAIL %s addr=%h load=%0b: tgt=%b zf=%b expected tgt=%b zf=%b",
               req, a, ld, tgt_sel, zero_fill, exp_t, exp_z);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    probe("R1", 32'h0000_0010, 1'b1, HOLE);
    probe("R1", 32'hEFE0_0000, 1'b1, MMIO);
    probe("R1", 32'h0100_0000, 1'b1, PCI);
    probe("R2", 32'h0000_00FF, 1'b1, HOLE);
    probe("R3", 32'h0000_0100, 1'b1, PCI);
  endtask

  task automatic t_store_hole;
    probe("R4", 32'h0000_0010, 1'b0, PCI);
    wr(2'd2, 32'h0000_0000);
    probe("R4", 32'h0000_0010, 1'b0, MMIO);
    probe("R3", 32'h0000_0010, 1'b1, HOLE);
  endtask

  task automatic t_mmio;
    wr(2'd2, 32'h4012_3456);
    probe("R9", 32'h4000_0000, 1'b1, MMIO);
    probe("R9", 32'h401F_FFFF, 1'b0, MMIO);
    probe("R9", 32'h4020_0000, 1'b1, PCI);
    probe("R11", 32'hEFE0_0000, 1'b1, PCI);
    probe("R10", 32'h3FFF_FFFF, 1'b1, PCI);
  endtask

  task automatic t_dram;
    wr(2'd0, 32'h1000_0000);
    wr(2'd1, 32'h10FF_FFFF);
    probe("R7", 32'h1000_0000, 1'b1, DRAM);
    probe("R7", 32'h10FF_FFFF, 1'b0, DRAM);
    probe("R7", 32'h1100_0000, 1'b1, PCI);
    probe("R7", 32'h0FFF_FFFF, 1'b1, PCI);
    probe("R3", 32'h0000_0020, 1'b1, HOLE);
    wr(2'd1, 32'h2FFF_FFFF);
    probe("R8", 32'h13FF_FFFF, 1'b1, DRAM);
    probe("R8", 32'h1400_0000, 1'b1, PCI);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'hBFFF_FFFF);
    probe("R7", 32'h83FF_FFFF, 1'b1, DRAM);
    probe("R7", 32'h7FFF_FFFF, 1'b1, PCI);
    wr(2'd2, 32'h8000_0000);
    probe("R7", 32'h8000_0010, 1'b1, DRAM);
    probe("R9", 32'h8400_0000, 1'b1, PCI);
    wr(2'd2, 32'h4000_0000);
  endtask

  task automatic t_overlap;
    wr(2'd0, 32'h0000_0080);
    wr(2'd1, 32'h0000_FFFF);
    probe("R5", 32'h0000_0010, 1'b1, PCI);
    probe("R5", 32'h0000_0090, 1'b1, DRAM);
    wr(2'd0, 32'h0000_0000);
    probe("R5", 32'h0000_0000, 1'b1, DRAM);
    wr(2'd0, 32'h1000_0000);
    wr(2'd1, 32'h10FF_FFFF);
    probe("R5", 32'h0000_0010, 1'b1, HOLE);
  endtask

  task automatic t_disable;
    wr(2'd3, 32'h0000_0000);
    probe("R6", 32'h0000_0010, 1'b1, PCI);
    probe("R6", 32'h0000_00FF, 1'b1, PCI);
    wr(2'd3, 32'h0000_0001);
    probe("R6", 32'h0000_0010, 1'b1, HOLE);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_store_hole();
        t_mmio();
        t_dram();
        t_overlap();
        t_disable();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule